// File: doc/BRIEF.md
# Operand Address Mode Resolver

This block sits in the operand stage of a small 8-bit controller core. For every decoded instruction it takes an addressing-mode code, the operand field taken from the instruction bytes, and a snapshot of the working registers, the accumulator, the 16-bit data pointer and the program counter. From these it works out where the operand lives. The result is an effective address and a two-bit code naming the target space: internal RAM, the special-function register space, program memory or external data memory.

The immediate mode returns the constant itself rather than an address, and flags it as such. Register-indirect and external accesses through a working register are legal only with the first two registers. Any other pointer choice raises an illegal flag instead of producing an address. All results are captured on an input strobe and held until the next strobe.

Top module: `oamr_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid_o`, `ea_o`, `space_o`, `imm_o` and `illegal_o` are all zero.
- R2: When `in_valid_i` is high at a rising edge, the outputs show the result for that cycle's inputs after that edge, with `out_valid_o` high. Otherwise `out_valid_o` goes low and `ea_o`, `space_o`, `imm_o` and `illegal_o` hold their values. The space codes are IRAM=0, SFR=1, CODE=2 and XDATA=3.
- R3: Mode 0 (immediate) gives `ea_o` equal to the full 16-bit `operand_i`, `imm_o`=1 and `space_o`=0.
- R4: Mode 1 (register) gives `ea_o` equal to `operand_i[2:0]` zero-extended, with `space_o`=0 (register file, carried in the IRAM code). Upper operand bits are ignored.
- R5: Mode 2 (direct) with `operand_i[7]`=0 gives `ea_o`={8'h00, operand_i[7:0]} and `space_o`=0. Bits 15:8 of the operand are ignored.
- R6: Mode 2 (direct) with `operand_i[7]`=1 gives `ea_o`={8'h00, operand_i[7:0]} and `space_o`=1.
- R7: Mode 3 (register-indirect) with pointer index `operand_i[2:0]` equal to 0 or 1 gives `ea_o` equal to that register's value zero-extended, and `space_o`=0, even when bit 7 of the pointer is set.
- R8: In mode 3 or mode 7, a pointer index of 2 to 7 gives `illegal_o`=1, `ea_o`=0, `space_o`=0 and `imm_o`=0.
- R9: Mode 4 gives `ea_o`=(dptr + zero-extended acc) mod 2^16 and `space_o`=2.
- R10: Mode 5 gives `ea_o`=(pc + zero-extended acc) mod 2^16 and `space_o`=2.
- R11: Mode 6 gives `ea_o`=dptr and `space_o`=3.
- R12: Mode 7 with pointer index 0 or 1 gives `ea_o`={8'h00, register value} and `space_o`=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Strobe: resolve this cycle's inputs |
| mode_i | input | 3 | Addressing-mode code 0..7 |
| operand_i | input | 16 | Operand field from the instruction bytes |
| regs_i | input | 64 | Working registers, register n in bits [8n+7:8n] |
| acc_i | input | 8 | Accumulator |
| dptr_i | input | 16 | Data pointer |
| pc_i | input | 16 | Program counter |
| out_valid_o | output | 1 | Result registered this cycle |
| ea_o | output | 16 | Effective address or immediate constant |
| space_o | output | 2 | Target space code |
| imm_o | output | 1 | `ea_o` carries an immediate constant |
| illegal_o | output | 1 | Illegal pointer register requested |

## Verification
The bench builds the block with its default parameters: eight 8-bit working registers and a 16-bit address. With these, the split of a direct address at bit 7 and the full set of six illegal pointer indices can be reached. So can the 16-bit wrap of the indexed sum, using a program counter near FFF8h and a data pointer of FFFFh. The register values are chosen with bit 7 set in one pointer. This shows that an indirect address above 7Fh stays in internal RAM, while a direct one at that value goes to the SFR space.

// File: rtl/oamr_pkg.sv
package oamr_pkg;

  typedef enum logic [2:0] {
    AM_IMM      = 3'd0,
    AM_REG      = 3'd1,
    AM_DIR      = 3'd2,
    AM_IND      = 3'd3,
    AM_IDX_DPTR = 3'd4,
    AM_IDX_PC   = 3'd5,
    AM_XD_DPTR  = 3'd6,
    AM_XD_RI    = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    SP_IRAM  = 2'd0,
    SP_SFR   = 2'd1,
    SP_CODE  = 2'd2,
    SP_XDATA = 2'd3
  } space_e;

endpackage

// File: rtl/oamr_ptr_pick.sv
module oamr_ptr_pick #(
  parameter int NREG    = 8,
  parameter int DATA_W  = 8,
  parameter int PTR_CNT = 2,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic [NREG*DATA_W-1:0] regs_i,
  input  logic [RIDX_W-1:0]      idx_i,
  output logic [DATA_W-1:0]      val_o,
  output logic                   legal_o
);

  logic [DATA_W-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign bank[g] = regs_i[g*DATA_W +: DATA_W];
  end

  function automatic logic ptr_ok(input logic [RIDX_W-1:0] idx);
    return (int'(idx) < PTR_CNT);
  endfunction

  assign val_o   = bank[idx_i];
  assign legal_o = ptr_ok(idx_i);

endmodule

// File: rtl/oamr_idx_add.sv
module oamr_idx_add #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] sum_o
);

  function automatic logic [ADDR_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    logic [ADDR_W:0] full;
    full = {1'b0, b} + {{(ADDR_W+1-DATA_W){1'b0}}, a};
    return full[ADDR_W-1:0];
  endfunction

  assign sum_o = wrap_add(acc_i, base_i);

endmodule

// File: rtl/oamr_dir_map.sv
module oamr_dir_map #(
  parameter int DIR_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic [DIR_W-1:0]  field_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              is_sfr_o
);

  assign addr_o   = {{(ADDR_W-DIR_W){1'b0}}, field_i};
  assign is_sfr_o = field_i[DIR_W-1];

endmodule

// File: rtl/oamr_top.sv
module oamr_top #(
  parameter int NREG    = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int DIR_W   = 8,
  parameter int PTR_CNT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid_i,
  input  logic [2:0]             mode_i,
  input  logic [ADDR_W-1:0]      operand_i,
  input  logic [NREG*DATA_W-1:0] regs_i,
  input  logic [DATA_W-1:0]      acc_i,
  input  logic [ADDR_W-1:0]      dptr_i,
  input  logic [ADDR_W-1:0]      pc_i,
  output logic                   out_valid_o,
  output logic [ADDR_W-1:0]      ea_o,
  output logic [1:0]             space_o,
  output logic                   imm_o,
  output logic                   illegal_o
);
  import oamr_pkg::*;

  localparam int RIDX_W = $clog2(NREG);

  logic [DATA_W-1:0] ptr_val_w;
  logic              ptr_legal_w;
  logic [ADDR_W-1:0] idx_base_w;
  logic [ADDR_W-1:0] idx_sum_w;
  logic [ADDR_W-1:0] dir_addr_w;
  logic              dir_is_sfr_w;

  logic [ADDR_W-1:0] n_ea;
  space_e            n_sp;
  logic              n_imm;
  logic              n_ill;

  oamr_ptr_pick #(
    .NREG(NREG), .DATA_W(DATA_W), .PTR_CNT(PTR_CNT)
  ) u_ptr (
    .regs_i (regs_i),
    .idx_i  (operand_i[RIDX_W-1:0]),
    .val_o  (ptr_val_w),
    .legal_o(ptr_legal_w)
  );

  assign idx_base_w = (mode_i == AM_IDX_PC) ? pc_i : dptr_i;

  oamr_idx_add #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_add (
    .acc_i (acc_i),
    .base_i(idx_base_w),
    .sum_o (idx_sum_w)
  );

  oamr_dir_map #(.DIR_W(DIR_W), .ADDR_W(ADDR_W)) u_dir (
    .field_i (operand_i[DIR_W-1:0]),
    .addr_o  (dir_addr_w),
    .is_sfr_o(dir_is_sfr_w)
  );

  always_comb begin
    n_ea  = '0;
    n_sp  = SP_IRAM;
    n_imm = 1'b0;
    n_ill = 1'b0;
    case (mode_i)
      AM_IMM: begin
        n_ea  = operand_i;
        n_imm = 1'b1;
      end
      AM_REG: n_ea = ADDR_W'(operand_i[RIDX_W-1:0]);
      AM_DIR: begin
        n_ea = dir_addr_w;
        n_sp = dir_is_sfr_w ? SP_SFR : SP_IRAM;
      end
      AM_IND: begin
        if (ptr_legal_w) n_ea = ADDR_W'(ptr_val_w);
        else             n_ill = 1'b1;
      end
      AM_IDX_DPTR, AM_IDX_PC: begin
        n_ea = idx_sum_w;
        n_sp = SP_CODE;
      end
      AM_XD_DPTR: begin
        n_ea = dptr_i;
        n_sp = SP_XDATA;
      end
      default: begin
        if (ptr_legal_w) begin
          n_ea = ADDR_W'(ptr_val_w);
          n_sp = SP_XDATA;
        end else begin
          n_ill = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      ea_o        <= '0;
      space_o     <= 2'd0;
      imm_o       <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        ea_o      <= n_ea;
        space_o   <= n_sp;
        imm_o     <= n_imm;
        illegal_o <= n_ill;
      end
    end
  end

endmodule

// File: rtl/oamr_chk.sv
module oamr_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid_i,
  input logic [2:0]        mode_i,
  input logic [ADDR_W-1:0] operand_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [ADDR_W-1:0] dptr_i,
  input logic              out_valid_o,
  input logic [ADDR_W-1:0] ea_o,
  input logic [1:0]        space_o,
  input logic              imm_o,
  input logic              illegal_o
);

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!out_valid_o && $stable(ea_o) && $stable(space_o)
                     && $stable(imm_o) && $stable(illegal_o)));

  // R3
  imm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && mode_i == 3'd0) |=> (imm_o && ea_o == $past(operand_i)));

  // R6
  sfr_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && mode_i == 3'd2 && operand_i[7]) |=> (space_o == 2'd1));

  // R8
  bad_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && (mode_i == 3'd3 || mode_i == 3'd7) && operand_i[2:1] != 2'b00)
      |=> (illegal_o && ea_o == '0 && !imm_o));

  // R9
  idx_dptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && mode_i == 3'd4) |=>
      (space_o == 2'd2 &&
       ea_o == ADDR_W'($past(dptr_i) + ADDR_W'($past(acc_i)))));

  // R3
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !(imm_o && illegal_o));

endmodule

bind oamr_top oamr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid_i (in_valid_i),
  .mode_i     (mode_i),
  .operand_i  (operand_i),
  .acc_i      (acc_i),
  .dptr_i     (dptr_i),
  .out_valid_o(out_valid_o),
  .ea_o       (ea_o),
  .space_o    (space_o),
  .imm_o      (imm_o),
  .illegal_o  (illegal_o)
);

// File: tb/tb_oamr_top.sv
`timescale 1ns/1ps
module tb_oamr_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [15:0] operand_i = '0;
  logic [63:0] regs_i;
  logic [7:0]  acc_i;
  logic [15:0] dptr_i;
  logic [15:0] pc_i;
  logic        out_valid_o;
  logic [15:0] ea_o;
  logic [1:0]  space_o;
  logic        imm_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  oamr_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .mode_i(mode_i),
    .operand_i(operand_i), .regs_i(regs_i), .acc_i(acc_i), .dptr_i(dptr_i),
    .pc_i(pc_i), .out_valid_o(out_valid_o), .ea_o(ea_o), .space_o(space_o),
    .imm_o(imm_o), .illegal_o(illegal_o)
  );

  typedef struct packed {
    logic [2:0]  m;
    logic [15:0] op;
    logic [15:0] ea;
    logic [1:0]  sp;
    logic        imm;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  // registers: R0=30h R1=C5h R2..R7=12h..17h; acc=F0h dptr=4532h pc=FFF8h
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h4532, 16'h4532, 2'd0, 1'b1, 1'b0, 4'd3},  // R3
    '{3'd0, 16'h0025, 16'h0025, 2'd0, 1'b1, 1'b0, 4'd3},  // R3
    '{3'd1, 16'h0005, 16'h0005, 2'd0, 1'b0, 1'b0, 4'd4},  // R4
    '{3'd1, 16'hFFF2, 16'h0002, 2'd0, 1'b0, 1'b0, 4'd4},  // R4
    '{3'd2, 16'h0040, 16'h0040, 2'd0, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd2, 16'hAB7F, 16'h007F, 2'd0, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd2, 16'h0080, 16'h0080, 2'd1, 1'b0, 1'b0, 4'd6},  // R6
    '{3'd2, 16'h12FF, 16'h00FF, 2'd1, 1'b0, 1'b0, 4'd6},  // R6
    '{3'd3, 16'h0000, 16'h0030, 2'd0, 1'b0, 1'b0, 4'd7},  // R7
    '{3'd3, 16'h0001, 16'h00C5, 2'd0, 1'b0, 1'b0, 4'd7},  // R7
    '{3'd3, 16'h0002, 16'h0000, 2'd0, 1'b0, 1'b1, 4'd8},  // R8
    '{3'd3, 16'h0007, 16'h0000, 2'd0, 1'b0, 1'b1, 4'd8},  // R8
    '{3'd7, 16'h0003, 16'h0000, 2'd0, 1'b0, 1'b1, 4'd8},  // R8
    '{3'd4, 16'h0000, 16'h4622, 2'd2, 1'b0, 1'b0, 4'd9},  // R9
    '{3'd5, 16'h0000, 16'h00E8, 2'd2, 1'b0, 1'b0, 4'd10}, // R10 wraps
    '{3'd6, 16'h0000, 16'h4532, 2'd3, 1'b0, 1'b0, 4'd11}, // R11
    '{3'd7, 16'h0001, 16'h00C5, 2'd3, 1'b0, 1'b0, 4'd12}, // R12
    '{3'd7, 16'h0000, 16'h0030, 2'd3, 1'b0, 1'b0, 4'd12}, // R12
    '{3'd3, 16'hFF04, 16'h0000, 2'd0, 1'b0, 1'b1, 4'd8},  // R8
    '{3'd0, 16'hFFFF, 16'hFFFF, 2'd0, 1'b1, 1'b0, 4'd3}   // R3
  };

  task automatic check(input int req, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, compare after the capturing rising edge
  task automatic apply(input logic [2:0] m, input logic [15:0] op,
                       input logic [15:0] ea, input logic [1:0] sp,
                       input logic imm, input logic ill, input int req);
    @(negedge clk);
    mode_i = m; operand_i = op; in_valid_i = 1'b1;
    @(negedge clk);
    check(req, {out_valid_o, ea_o, space_o, imm_o, illegal_o},
               {1'b1, ea, sp, imm, ill});
    in_valid_i = 1'b0;
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    regs_i = {8'h17, 8'h16, 8'h15, 8'h14, 8'h13, 8'h12, 8'hC5, 8'h30};
    acc_i  = 8'hF0;
    dptr_i = 16'h4532;
    pc_i   = 16'hFFF8;

    // R1: reset state
    #7;
    check(1, {out_valid_o, ea_o, space_o, imm_o, illegal_o}, 21'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(1, {out_valid_o, ea_o, space_o, imm_o, illegal_o}, 21'd0);

    for (int i = 0; i < NV; i++)
      apply(VECS[i].m, VECS[i].op, VECS[i].ea, VECS[i].sp,
            VECS[i].imm, VECS[i].ill, int'(VECS[i].req));

    // R9: 16-bit wrap of the data-pointer sum
    dptr_i = 16'hFFFF; acc_i = 8'h01;
    apply(3'd4, 16'h0000, 16'h0000, 2'd2, 1'b0, 1'b0, 9);

    // R2: no strobe -> outputs hold, valid drops, though inputs change
    apply(3'd2, 16'h00A0, 16'h00A0, 2'd1, 1'b0, 1'b0, 2);
    @(negedge clk);
    mode_i = 3'd0; operand_i = 16'h1234; dptr_i = 16'h0BAD;
    @(negedge clk);
    @(negedge clk);
    check(2, {out_valid_o, ea_o, space_o, imm_o, illegal_o},
             {1'b0, 16'h00A0, 2'd1, 1'b0, 1'b0});

    // R11: new data pointer picked up with no stale value
    apply(3'd6, 16'h0000, 16'h0BAD, 2'd3, 1'b0, 1'b0, 11);

    // R1: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    #1;
    check(1, {out_valid_o, ea_o, space_o, imm_o, illegal_o}, 21'd0);
    @(negedge clk); rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule